// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit binary adder. It takes two operands and a carry input, and it returns a 16-bit sum and the carry out of the top bit. It is meant for a datapath where the add has to settle in a few gate levels instead of waiting on a carry that ripples through every bit.

Each bit makes a generate term (both operand bits set) and a propagate term (either operand bit set). The bits are grouped four to a group. Inside each group, every carry is written as a full sum of products of that group's bit terms and its incoming carry. Each group also reduces its bits to one group generate and one group propagate. A second lookahead level uses those group terms and the primary carry input to form the carry into groups 1, 2 and 3 and the final carry out. Each of these is also a fully expanded sum of products, so no group waits on the group below it. Each sum bit is the XOR of the two operand bits and the carry into that bit.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals `a_in + b_in + carry_in` modulo 2^16 for every input combination.
- R2: `carry_out` equals bit 16 of the 17-bit value `a_in + b_in + carry_in`.
- R3: With both operands zero and `carry_in` low, `sum_out` is 0x0000 and `carry_out` is 0.
- R4: When every bit position holds exactly one set operand bit (`a_in ^ b_in` = 0xFFFF, so nothing generates) and `carry_in` is high, the carry travels through all four groups: `sum_out` is 0x0000 and `carry_out` is 1.
- R5: When no bit position has both operand bits set (`a_in & b_in` = 0) and `carry_in` is low, `carry_out` is 0.
- R6: Propagate is the OR of the operand bits. When `a_in | b_in` = 0xFFFF and `carry_in` is high, `carry_out` is 1, and this holds even where positions generate.
- R7: A carry generated in one group reaches the next group. For example, 0x000F + 0x0001 gives 0x0010, 0x0FFF + 0x0001 gives 0x1000, and a carry generated at bit 0 with all other positions propagating (0x0001 + 0xFFFF) gives a sum of 0x0000 with `carry_out` 1.
- R8: Swapping `a_in` and `b_in` leaves `sum_out` and `carry_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The bound checker re-evaluates the adder whenever the inputs change. It checks the arithmetic identity for the sum and the carry out. It also checks the carry-only properties: zero inputs give zero outputs, a full propagate chain carries all the way through, the carry out stays low when nothing generates, and an OR-covered word with carry in produces a carry out. Only the bench's scenarios can show the operand-swap symmetry, because that compares two different input vectors. The same holds for the specific carry crossings at group boundaries, which the bench drives as directed vectors alongside a seeded random sweep.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Largest span one lookahead stage has to handle.
    localparam int LA_MAX = 8;

    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    // Carries into positions 1..n of a span, each one formed as a sum of
    // products over the span's generate/propagate terms and its carry-in.
    // Bit 0 of the result is the carry-in itself.
    function automatic logic [LA_MAX:0] la_carries(
        input logic [LA_MAX-1:0] g,
        input logic [LA_MAX-1:0] p,
        input logic              cin,
        input int                n
    );
        logic [LA_MAX:0] c;
        logic            acc;
        logic            chain;
        c    = '0;
        c[0] = cin;
        for (int k = 0; k < LA_MAX; k++) begin
            if (k < n) begin
                acc   = 1'b0;
                chain = 1'b1;
                for (int j = LA_MAX - 1; j >= 0; j--) begin
                    if (j <= k) begin
                        acc   = acc | (g[j] & chain);
                        chain = chain & p[j];
                    end
                end
                c[k+1] = acc | (chain & cin);
            end
        end
        return c;
    endfunction

    // Group generate and propagate of an n-wide span.
    function automatic gp_t la_group(
        input logic [LA_MAX-1:0] g,
        input logic [LA_MAX-1:0] p,
        input int                n
    );
        gp_t  r;
        logic chain;
        r.gen = 1'b0;
        chain = 1'b1;
        for (int j = LA_MAX - 1; j >= 0; j--) begin
            if (j < n) begin
                r.gen = r.gen | (g[j] & chain);
                chain = chain & p[j];
            end
        end
        r.prop = chain;
        return r;
    endfunction

endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] g,
    output logic [W-1:0] p,
    output logic [W-1:0] h
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign g[i] = a[i] & b[i];
        assign p[i] = a[i] | b[i];
        assign h[i] = a[i] ^ b[i];
    end
endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic [GW-1:0] g,
    input  logic [GW-1:0] p,
    input  logic          cin,
    output logic [GW-1:0] c,
    output gp_t           grp
);
    logic [LA_MAX-1:0] gx;
    logic [LA_MAX-1:0] px;
    logic [LA_MAX:0]   cx;

    always_comb begin
        gx         = '0;
        px         = '0;
        gx[GW-1:0] = g;
        px[GW-1:0] = p;
        cx         = la_carries(gx, px, cin, GW);
        c          = cx[GW-1:0];
        grp        = la_group(gx, px, GW);
    end
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit
    import cla_pkg::*;
#(
    parameter int NG = 4
) (
    input  gp_t [NG-1:0] grp,
    input  logic         c0,
    output logic [NG:0]  gc
);
    logic [LA_MAX-1:0] gx;
    logic [LA_MAX-1:0] px;
    logic [LA_MAX:0]   cx;

    always_comb begin
        gx = '0;
        px = '0;
        for (int k = 0; k < NG; k++) begin
            gx[k] = grp[k].gen;
            px[k] = grp[k].prop;
        end
        cx = la_carries(gx, px, c0, NG);
        gc = cx[NG:0];
    end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int GRP_W = 4,
    parameter int N_GRP = 4
) (
    input  logic [GRP_W*N_GRP-1:0] a_in,
    input  logic [GRP_W*N_GRP-1:0] b_in,
    input  logic                   carry_in,
    output logic [GRP_W*N_GRP-1:0] sum_out,
    output logic                   carry_out
);
    localparam int W = GRP_W * N_GRP;

    logic [W-1:0]       bit_g;
    logic [W-1:0]       bit_p;
    logic [W-1:0]       bit_h;
    logic [W-1:0]       bit_c;
    gp_t  [N_GRP-1:0]   grp_t;
    logic [N_GRP:0]     grp_c;

    cla_bit_terms #(.W(W)) u_terms (
        .a (a_in),
        .b (b_in),
        .g (bit_g),
        .p (bit_p),
        .h (bit_h)
    );

    for (genvar k = 0; k < N_GRP; k++) begin : g_grp
        cla_group #(.GW(GRP_W)) u_grp (
            .g   (bit_g[k*GRP_W +: GRP_W]),
            .p   (bit_p[k*GRP_W +: GRP_W]),
            .cin (grp_c[k]),
            .c   (bit_c[k*GRP_W +: GRP_W]),
            .grp (grp_t[k])
        );
    end

    cla_carry_unit #(.NG(N_GRP)) u_top (
        .grp (grp_t),
        .c0  (carry_in),
        .gc  (grp_c)
    );

    assign sum_out   = bit_h ^ bit_c;
    assign carry_out = grp_c[N_GRP];
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
    parameter int GRP_W = 4,
    parameter int N_GRP = 4
) (
    input logic [GRP_W*N_GRP-1:0] a_in,
    input logic [GRP_W*N_GRP-1:0] b_in,
    input logic                   carry_in,
    input logic [GRP_W*N_GRP-1:0] sum_out,
    input logic                   carry_out
);
    localparam int W = GRP_W * N_GRP;
    logic [W:0] ref_total;

    always_comb begin
        ref_total = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, carry_in};
        assert_sum_R1: assert (sum_out == ref_total[W-1:0]);
        assert_cout_R2: assert (carry_out == ref_total[W]);
        if (a_in == '0 && b_in == '0 && !carry_in)
            assert_zero_R3: assert (sum_out == '0 && !carry_out);
        if ((a_in ^ b_in) == {W{1'b1}} && carry_in)
            assert_chain_R4: assert (sum_out == '0 && carry_out);
        if ((a_in & b_in) == '0 && !carry_in)
            assert_nogen_R5: assert (!carry_out);
        if ((a_in | b_in) == {W{1'b1}} && carry_in)
            assert_orprop_R6: assert (carry_out);
    end
endmodule

bind cla16_adder cla16_adder_chk #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
);

// File: tb/sim_cla16_adder.sv
module sim_cla16_adder;
    logic        clk = 1'b0;
    logic [15:0] a_in;
    logic [15:0] b_in;
    logic        carry_in;
    logic [15:0] sum_out;
    logic        carry_out;
    int          n_vec  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;

    cla16_adder u0 (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    function automatic logic [16:0] exp_total(logic [15:0] a, logic [15:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {16'd0, c};
    endfunction

    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic c);
        @(negedge clk);
        a_in     = a;
        b_in     = b;
        carry_in = c;
        @(posedge clk);
        #1;
    endtask

    // Drive one vector and compare both outputs with the arithmetic model.
    task automatic check_vec(input logic [15:0] a, input logic [15:0] b,
                             input logic c, input string tag);
        logic [16:0] e;
        drive(a, b, c);
        e = exp_total(a, b, c);
        n_vec++;
        if (sum_out !== e[15:0]) begin
            n_fail++;
            $display("FAIL %s R1 sum: a=%h b=%h c=%b actual=%h expected=%h",
                     tag, a, b, c, sum_out, e[15:0]);
        end
        if (carry_out !== e[16]) begin
            n_fail++;
            $display("FAIL %s R2 carry: a=%h b=%h c=%b actual=%b expected=%b",
                     tag, a, b, c, carry_out, e[16]);
        end
    endtask

    task automatic check_swap(input logic [15:0] a, input logic [15:0] b, input logic c);
        logic [15:0] s1;
        logic        c1;
        drive(a, b, c);
        s1 = sum_out;
        c1 = carry_out;
        drive(b, a, c);
        n_vec++;
        if (sum_out !== s1 || carry_out !== c1) begin
            n_fail++;
            $display("FAIL R8 swap: a=%h b=%h actual=%h/%b expected=%h/%b",
                     a, b, sum_out, carry_out, s1, c1);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        check_vec(16'h0000, 16'h0000, 1'b0, "R3_zero");
        check_vec(16'hFFFF, 16'h0000, 1'b1, "R4_chain");
        check_vec(16'hA5A5, 16'h5A5A, 1'b1, "R4_mixed_chain");
        check_vec(16'h5555, 16'hAAAA, 1'b0, "R5_nogen");
        check_vec(16'hF0F0, 16'h0F0F, 1'b0, "R5_nogen_b");
        check_vec(16'hFFFF, 16'hFFFF, 1'b1, "R6_all");
        check_vec(16'hFF0F, 16'h00F1, 1'b1, "R6_overlap");
        check_vec(16'h000F, 16'h0001, 1'b0, "R7_g0_to_g1");
        check_vec(16'h00FF, 16'h0001, 1'b0, "R7_g1_to_g2");
        check_vec(16'h0FFF, 16'h0001, 1'b0, "R7_g2_to_g3");
        check_vec(16'h0001, 16'hFFFF, 1'b0, "R7_bit0_gen");
        check_vec(16'h8000, 16'h8000, 1'b0, "R2_top_gen");
        check_vec(16'h7FFF, 16'h0000, 1'b1, "R1_to_msb");
        check_swap(16'h1234, 16'hFEDC, 1'b1);
        check_swap(16'h00F0, 16'h0F10, 1'b0);
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            check_vec(ra, rb, 1'($urandom), "R1_R2_random");
            if (i % 100 == 0) check_swap(ra, rb, 1'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule